// File: doc/BRIEF.md
# Register-Mapped Iterative Factorial Unit

This block is a small register target that computes 32-bit factorials in hardware. Software writes an operand to the operand register and the unit begins a multiply loop, doing one multiplication per clock. While the loop runs, a busy flag in the status register is set and the operand register keeps the value that was written. When the loop ends, the product replaces the operand in that same register and the busy flag drops. If software has set the interrupt-enable bit in the status register, the unit also emits a one-cycle completion pulse.

Two more registers sit next to the engine. One is a read-only identification word. The other is a scratch register that stores the bitwise complement of whatever is written to it. All accesses go through a single-cycle request port. A request carries a transfer-size code, and the block enforces the width rules for each offset. Every read gets a registered response one cycle after it is issued. A read that breaks a rule, or that targets an unmapped offset, returns all ones. A write that breaks a rule is dropped.

Top module: `fact_unit`

## Requirements
- R1: Offset 0x00 reads the constant 0x010000ED. Writes to it have no effect.
- R2: A valid write to offset 0x04 stores the bitwise inverse of the write data, and a read of 0x04 returns that stored value.
- R3: A valid write to offset 0x08 while idle loads the operand and sets status bit 0 (busy). While busy, reads of 0x08 return the operand as written.
- R4: A write to offset 0x08 while busy is ignored: neither the operand nor the result changes.
- R5: On completion, offset 0x08 holds n·(n−1)·…·1 truncated to 32 bits, starting from 1, so operand 0 gives 1 and operand 13 gives 0x7328CC00.
- R6: After the write edge that starts the loop, busy stays set for exactly n+1 clock cycles.
- R7: Status offset 0x20 reads busy at bit 0 and interrupt-enable at bit 7, with all other bits zero. Software writes bit 7 directly. Bit 0 cannot be written.
- R8: `done_irq` pulses high for one cycle, in the same cycle busy clears, only if interrupt-enable is set at completion. Otherwise it stays low.
- R9: Size code 2 means 32 bits, code 3 means 64 bits, and codes 0 and 1 are narrower. Below offset 0x80 only code 2 is valid. At 0x80 and above, codes 2 and 3 are valid. An invalid read returns 0xFFFFFFFF and an invalid write changes nothing.
- R10: Reads of any offset other than 0x00, 0x04, 0x08 and 0x20 return 0xFFFFFFFF.
- R11: Every read request produces `rsp_valid` high for exactly the following cycle, with `rsp_rdata` valid in that cycle.
- R12: After reset, the scratch register, the operand, busy and interrupt-enable are all zero, and `done_irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_size | input | 2 | Transfer-size code (2 = 32 bit, 3 = 64 bit) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | DATA_W | Read response data |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the following about the inputs: each request is held for exactly one clock, addresses are word aligned, and no request arrives during the two cycles in which the internal reset is released. The bench drives every request on the falling edge and keeps it for one cycle. It waits several cycles after reset before its first access. It uses only word-aligned offsets, including for the unmapped and wide-region probes. Because of this, the busy-window, pulse and response-timing properties are exercised only under the single-beat request pattern that they take for granted.

// File: rtl/fact_pkg.sv
package fact_pkg;
  localparam logic [7:0]  OFS_ID      = 8'h00;
  localparam logic [7:0]  OFS_SCRATCH = 8'h04;
  localparam logic [7:0]  OFS_OPND    = 8'h08;
  localparam logic [7:0]  OFS_STAT    = 8'h20;
  localparam logic [7:0]  WIDE_BASE   = 8'h80;
  localparam logic [31:0] ID_WORD     = 32'h010000ED;
  localparam int          STAT_BUSY   = 0;
  localparam int          STAT_IEN    = 7;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/fact_rst_sync.sv
module fact_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fact_access_gate.sv
module fact_access_gate
  import fact_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              rd_ok,
  output logic              wr_ok
);
  localparam logic [ADDR_W-1:0] WIDE_LO = ADDR_W'(WIDE_BASE);

  logic size_legal;

  always_comb begin
    size_legal = (req_size == SZ_WORD) ||
                 ((req_addr >= WIDE_LO) && (req_size == SZ_DBL));
    rd_ok = req_valid && !req_write && size_legal;
    wr_ok = req_valid &&  req_write && size_legal;
  end
endmodule

// File: rtl/fact_core.sv
module fact_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] start_val,
  input  logic              ien,
  output logic              busy,
  output logic [DATA_W-1:0] opnd,
  output logic              irq
);
  logic              busy_q, busy_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [DATA_W-1:0] opnd_q, opnd_d;
  logic              irq_q, irq_d;
  logic              run_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    opnd_d = opnd_q;
    irq_d  = 1'b0;
    if (busy_q) begin
      if (cnt_q == '0) begin
        opnd_d = acc_q;
        busy_d = 1'b0;
        irq_d  = ien;
      end else begin
        acc_d = acc_q * cnt_q;
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start) begin
      opnd_d = start_val;
      cnt_d  = start_val;
      acc_d  = DATA_W'(1);
      busy_d = 1'b1;
    end
  end

  assign run_en = busy_q | start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      opnd_q <= '0;
    end else if (run_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      opnd_q <= opnd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign busy = busy_q;
  assign opnd = opnd_q;
  assign irq  = irq_q;

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q); // R3
  AST_OPND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> $stable(opnd_q)); // R4
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == '0) |=> !busy_q); // R6
  AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $fell(busy_q)); // R8
endmodule

// File: rtl/fact_unit.sv
module fact_unit
  import fact_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              done_irq
);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFS_ID);
  localparam logic [ADDR_W-1:0] A_SCR  = ADDR_W'(OFS_SCRATCH);
  localparam logic [ADDR_W-1:0] A_OPND = ADDR_W'(OFS_OPND);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic              rst_ns;
  logic              rd_ok, wr_ok;
  logic              busy;
  logic [DATA_W-1:0] opnd;
  logic              start;
  logic [DATA_W-1:0] scratch_q, scratch_d;
  logic              ien_q, ien_d;
  logic              rvalid_q, rvalid_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] stat_word;

  fact_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  fact_access_gate #(.ADDR_W(ADDR_W)) i_gate (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  assign start = wr_ok && (req_addr == A_OPND);

  fact_core #(.DATA_W(DATA_W)) i_core (
    .clk(clk), .rst_n(rst_ns), .start(start), .start_val(req_wdata),
    .ien(ien_q), .busy(busy), .opnd(opnd), .irq(done_irq)
  );

  always_comb begin
    stat_word            = '0;
    stat_word[STAT_BUSY] = busy;
    stat_word[STAT_IEN]  = ien_q;

    scratch_d = scratch_q;
    ien_d     = ien_q;
    if (wr_ok && req_addr == A_SCR)  scratch_d = ~req_wdata;
    if (wr_ok && req_addr == A_STAT) ien_d     = req_wdata[STAT_IEN];

    rvalid_d = req_valid && !req_write;
    rdata_d  = '1;
    if (rd_ok) begin
      case (req_addr)
        A_ID:    rdata_d = DATA_W'(ID_WORD);
        A_SCR:   rdata_d = scratch_q;
        A_OPND:  rdata_d = opnd;
        A_STAT:  rdata_d = stat_word;
        default: rdata_d = '1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      scratch_q <= '0;
      ien_q     <= 1'b0;
    end else if (wr_ok) begin
      scratch_q <= scratch_d;
      ien_q     <= ien_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      if (rvalid_d) rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = rvalid_q;
  assign rsp_rdata = rdata_q;

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && !req_write) |=> rsp_valid); // R11
  AST_BAD_READ_ONES: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && !req_write && !rd_ok) |=> (rsp_rdata == '1)); // R9
  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_ok && req_addr == A_ID) |=> (rsp_rdata == DATA_W'(ID_WORD))); // R1
endmodule

// File: tb/test_fact_unit.sv
module test_fact_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        done_irq;

  int checks = 0;
  int failures = 0;
  int irq_seen = 0;
  bit model_on = 1'b0;

  always #5 clk = ~clk;

  fact_unit i_fact_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .done_irq(done_irq)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_opnd, m_scr, m_acc, m_cnt, e_rdata;
  bit          m_busy, m_ien, e_rvalid, e_irq;
  string       e_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_opnd = 0; m_scr = 0; m_acc = 0; m_cnt = 0;
      m_busy = 0; m_ien = 0; e_rvalid = 0; e_irq = 0; e_rdata = 0; e_tag = "R12";
    end else begin
      bit ok, was_busy;
      ok = (req_size == 2'd2) || (req_addr >= 8'h80 && req_size == 2'd3);
      was_busy = m_busy;
      e_rvalid = req_valid && !req_write;
      if (e_rvalid) begin
        e_rdata = 32'hFFFF_FFFF;
        e_tag = "R10";
        if (!ok) e_tag = "R9";
        else if (req_addr == 8'h00) begin e_rdata = 32'h010000ED; e_tag = "R1"; end
        else if (req_addr == 8'h04) begin e_rdata = m_scr; e_tag = "R2"; end
        else if (req_addr == 8'h08) begin e_rdata = m_opnd; e_tag = "R5"; end
        else if (req_addr == 8'h20) begin
          e_rdata = {24'd0, m_ien, 6'd0, m_busy}; e_tag = "R7";
        end
      end
      e_irq = 0;
      if (m_busy) begin
        if (m_cnt == 0) begin m_opnd = m_acc; m_busy = 0; e_irq = m_ien; end
        else begin m_acc = m_acc * m_cnt; m_cnt = m_cnt - 1; end
      end
      if (req_valid && req_write && ok) begin
        if (req_addr == 8'h04) m_scr = ~req_wdata;
        if (req_addr == 8'h20) m_ien = req_wdata[7];
        if (req_addr == 8'h08 && !was_busy) begin
          m_opnd = req_wdata; m_cnt = req_wdata; m_acc = 1; m_busy = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (done_irq) irq_seen++;
    if (model_on) begin
      check("R11 rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rvalid});
      check("R8 done_irq", {31'd0, done_irq}, {31'd0, e_irq});
      if (e_rvalid) check({e_tag, " model rdata"}, rsp_rdata, e_rdata);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] s = 2'd2);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_size = s;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_size = 2'd2;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [1:0] s = 2'd2);
    req_valid = 1; req_write = 0; req_addr = a; req_size = s;
    @(negedge clk);
    req_valid = 0; req_size = 2'd2;
    d = rsp_rdata;
  endtask

  task automatic run_fact(input logic [31:0] n, output int busy_reads);
    logic [31:0] v;
    wr(8'h08, n);
    busy_reads = 0;
    for (int i = 0; i < 200; i++) begin
      rd(8'h20, v);
      if (v[0]) busy_reads++;
      else break;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int nb, irq0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    model_on = 1;

    check("R12 irq after reset", {31'd0, done_irq}, 32'd0);
    rd(8'h20, v); check("R12 status reset", v, 32'd0);
    rd(8'h08, v); check("R12 operand reset", v, 32'd0);
    rd(8'h04, v); check("R12 scratch reset", v, 32'd0);
    rd(8'h00, v); check("R1 id", v, 32'h010000ED);
    wr(8'h00, 32'h1234_5678);
    rd(8'h00, v); check("R1 id after write", v, 32'h010000ED);

    wr(8'h04, 32'h1234_5678);
    rd(8'h04, v); check("R2 scratch inverse", v, 32'hEDCB_A987);
    wr(8'h04, 32'h0);
    rd(8'h04, v); check("R2 scratch ones", v, 32'hFFFF_FFFF);

    // width rules
    wr(8'h04, 32'h5555_5555, 2'd3);
    rd(8'h04, v); check("R9 wide write dropped", v, 32'hFFFF_FFFF);
    wr(8'h04, 32'h5555_5555, 2'd0);
    rd(8'h04, v); check("R9 byte write dropped", v, 32'hFFFF_FFFF);
    rd(8'h00, v, 2'd3); check("R9 wide read low", v, 32'hFFFF_FFFF);
    rd(8'h00, v, 2'd1); check("R9 half read", v, 32'hFFFF_FFFF);
    rd(8'h80, v, 2'd3); check("R10 wide region", v, 32'hFFFF_FFFF);
    rd(8'h80, v, 2'd0); check("R9 narrow high", v, 32'hFFFF_FFFF);
    rd(8'h10, v); check("R10 unmapped", v, 32'hFFFF_FFFF);
    wr(8'h08, 32'd7, 2'd1);
    rd(8'h20, v); check("R9 bad operand write", v, 32'd0);

    // status bits
    wr(8'h20, 32'h0000_007F);
    rd(8'h20, v); check("R7 busy not writable", v, 32'd0);
    wr(8'h20, 32'h0000_0080);
    rd(8'h20, v); check("R7 ien set", v, 32'h80);

    // factorial runs with interrupt enabled
    irq0 = irq_seen;
    wr(8'h08, 32'd5);
    rd(8'h08, v); check("R3 operand held", v, 32'd5);
    rd(8'h20, v); check("R3 busy set", v, 32'h81);
    repeat (10) @(negedge clk);
    rd(8'h08, v); check("R5 5!", v, 32'd120);
    check("R8 one pulse", irq_seen - irq0, 1);

    run_fact(32'd0, nb);
    check("R6 busy n=0", nb, 1);
    rd(8'h08, v); check("R5 0!", v, 32'd1);
    run_fact(32'd5, nb);
    check("R6 busy n=5", nb, 6);
    run_fact(32'd13, nb);
    rd(8'h08, v); check("R5 13! truncated", v, 32'h7328_CC00);

    // write while busy ignored
    wr(8'h08, 32'd4);
    wr(8'h08, 32'd9);
    rd(8'h08, v); check("R4 operand kept", v, 32'd4);
    repeat (8) @(negedge clk);
    rd(8'h08, v); check("R4 result of first", v, 32'd24);

    // interrupt disabled
    wr(8'h20, 32'h0);
    irq0 = irq_seen;
    run_fact(32'd3, nb);
    repeat (3) @(negedge clk);
    check("R8 no pulse when disabled", irq_seen - irq0, 0);
    rd(8'h08, v); check("R5 3!", v, 32'd6);

    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule